// File: doc/BRIEF.md
# Calendar Update Engine with Daylight-Saving Jumps

This block keeps wall-clock time as seconds, minutes, hours, weekday, day of month, month and two-digit year. An external one-second strobe starts each update. A warning window opens first and the update flag is raised during it. When a programmable number of clock cycles has passed, the internal time advances by one second. If the host is not holding the set control, the new time is copied into the user-visible register bytes and an update-done pulse follows.

The internal counters are always kept in plain binary with a 0–23 hour. A codec converts them into the user bytes in the selected encoding (binary or BCD) and hour format (24-hour, or 12-hour with a PM flag in bit 7), and converts user bytes back. While the host holds set, the user bytes are frozen and accept writes, and the internal time keeps counting. On release, bytes the host wrote become the new time. Optional daylight-saving jumps skip the 2 AM hour in spring and repeat the 1 AM hour once in autumn.

Top module: `cal_engine`

## Requirements
- R1: After reset the user bytes read 0x00 (second, minute, hour, year) and 0x01 (weekday, date, month), and uip and upd_done are low.
- R2: A sec_tick sampled while no update is pending and set_hold is low raises uip in the next cycle. The time advances UIP_DELAY cycles after the tick, and uip falls in the same cycle. Ticks that arrive while an update is pending are ignored.
- R3: Byte addresses are 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month, 6 year. With bin_mode=1 the bytes are binary. With bin_mode=0 they are BCD, with the tens digit in bits 7:4.
- R4: Seconds and minutes wrap 59→0 and hours wrap 23→0. The weekday cycles 1..7 (1 = Sunday). The date wraps after the month length, the month wraps 12→1 and the year wraps 99→0. February has 29 days when the year is divisible by 4 and 28 otherwise.
- R5: With hr24_mode=0 the hour byte holds 1..12 plus a PM flag in bit 7. 11:59:59 AM is followed by 12:00:00 PM, 12:59:59 is followed by 1:00:00 with the same PM flag, and 11:59:59 PM is followed by 12:00:00 AM.
- R6: While set_hold is high, uip reads 0 from the next cycle on and the user bytes do not change except through host writes. The internal time still advances on each update and upd_done still pulses.
- R7: Host writes take effect only while set_hold is high. A write with set_hold low leaves the byte unchanged.
- R8: When set_hold falls after at least one accepted write, the user bytes are decoded into the internal time. If the release falls in the same cycle as an advance, the advance is applied to the decoded time.
- R9: With dst_en=1, 01:59:59 on a Sunday in April with date 1..7 is followed by 03:00:00. With dst_en=0 it is followed by 02:00:00.
- R10: With dst_en=1, 01:59:59 on a Sunday in October with date 25 or later is followed by 01:00:00 the first time. On the next pass it is followed by 02:00:00.
- R11: upd_done is a one-cycle pulse in the cycle after each advance, when the new values are readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second strobe, one cycle wide |
| set_hold | input | 1 | Freeze user bytes and enable host writes |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enable daylight-saving jumps |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Byte address for read and write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Registered read of the addressed user byte |
| uip | output | 1 | Update pending flag |
| upd_done | output | 1 | Update-done pulse |

## Verification
The case that needs the most care is a set_hold release in the same cycle as an advance. The bench holds set_hold, writes a time, issues a tick, and lowers set_hold so that the release is sampled at exactly the edge of the advance. It then expects the written time plus one second in the user bytes. A behavioural reference model, compared on every clock, also covers ticks and host writes that fall inside the warning window.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF = 7;
  localparam int AW = 3;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } cal_time_t;

  localparam cal_time_t TIME_RST = '{sec: 6'd0, min: 6'd0, hr: 5'd0, dow: 3'd1,
                                     date: 5'd1, mon: 4'd1, yr: 7'd0};

  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : 7'(b[7:4] * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [4:0] days_in(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                   return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_step.sv
module cal_step
  import cal_pkg::*;
(
  input  cal_time_t cur,
  input  logic      dst_en,
  input  logic      fall_done,
  output cal_time_t nxt,
  output logic      fall_done_nxt
);
  logic at_one59;
  logic spring;
  logic fall;

  always_comb begin
    at_one59 = (cur.hr == 5'd1) && (cur.min == 6'd59) && (cur.sec == 6'd59) && (cur.dow == 3'd1);
    spring   = dst_en && at_one59 && (cur.mon == 4'd4) && (cur.date <= 5'd7);
    fall     = dst_en && at_one59 && (cur.mon == 4'd10) && (cur.date >= 5'd25) && !fall_done;
    nxt           = cur;
    fall_done_nxt = fall_done;
    if (spring) begin
      nxt.sec = 6'd0;
      nxt.min = 6'd0;
      nxt.hr  = 5'd3;
    end else if (fall) begin
      nxt.sec       = 6'd0;
      nxt.min       = 6'd0;
      nxt.hr        = 5'd1;
      fall_done_nxt = 1'b1;
    end else begin
      if (cur.sec < 6'd59) nxt.sec = cur.sec + 6'd1;
      else begin
        nxt.sec = 6'd0;
        if (cur.min < 6'd59) nxt.min = cur.min + 6'd1;
        else begin
          nxt.min = 6'd0;
          if (cur.hr < 5'd23) nxt.hr = cur.hr + 5'd1;
          else begin
            nxt.hr  = 5'd0;
            nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date < days_in(cur.mon, cur.yr)) nxt.date = cur.date + 5'd1;
            else begin
              nxt.date = 5'd1;
              if (cur.mon < 4'd12) nxt.mon = cur.mon + 4'd1;
              else begin
                nxt.mon = 4'd1;
                nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
              end
            end
          end
        end
      end
      if (nxt.hr != 5'd1) fall_done_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/cal_codec.sv
module cal_codec
  import cal_pkg::*;
(
  input  cal_time_t             t_in,
  input  logic [NF-1:0][7:0]    bytes_in,
  input  logic                  bin,
  input  logic                  h24,
  output logic [NF-1:0][7:0]    bytes_out,
  output cal_time_t             t_out
);
  logic [4:0] h12;
  logic [7:0] h12_byte;
  logic [6:0] h12_dec;
  logic       pm_dec;

  always_comb begin
    h12      = (t_in.hr == 5'd0) ? 5'd12 : (t_in.hr > 5'd12) ? t_in.hr - 5'd12 : t_in.hr;
    h12_byte = enc_val({2'b00, h12}, bin);
    bytes_out[0] = enc_val({1'b0, t_in.sec}, bin);
    bytes_out[1] = enc_val({1'b0, t_in.min}, bin);
    bytes_out[2] = h24 ? enc_val({2'b00, t_in.hr}, bin)
                       : {(t_in.hr >= 5'd12), h12_byte[6:0]};
    bytes_out[3] = enc_val({4'd0, t_in.dow}, bin);
    bytes_out[4] = enc_val({2'b00, t_in.date}, bin);
    bytes_out[5] = enc_val({3'd0, t_in.mon}, bin);
    bytes_out[6] = enc_val(t_in.yr, bin);
  end

  always_comb begin
    h12_dec = dec_val({1'b0, bytes_in[2][6:0]}, bin);
    pm_dec  = bytes_in[2][7];
    t_out.sec  = 6'(dec_val(bytes_in[0], bin));
    t_out.min  = 6'(dec_val(bytes_in[1], bin));
    if (h24) t_out.hr = 5'(dec_val(bytes_in[2], bin));
    else if (h12_dec == 7'd12) t_out.hr = pm_dec ? 5'd12 : 5'd0;
    else t_out.hr = pm_dec ? 5'(h12_dec + 7'd12) : 5'(h12_dec);
    t_out.dow  = 3'(dec_val(bytes_in[3], bin));
    t_out.date = 5'(dec_val(bytes_in[4], bin));
    t_out.mon  = 4'(dec_val(bytes_in[5], bin));
    t_out.yr   = dec_val(bytes_in[6], bin);
  end
endmodule

// File: rtl/cal_user_regs.sv
module cal_user_regs #(
  parameter int NB = 7,
  parameter int AB = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AB-1:0]       addr,
  input  logic [7:0]          wr_data,
  input  logic                ld_en,
  input  logic [NB-1:0][7:0]  ld_data,
  output logic [NB-1:0][7:0]  bytes_q,
  output logic [7:0]          rd_data
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [7:0] RST_V = (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)                                  bytes_q[i] <= RST_V;
      else if (ld_en)                           bytes_q[i] <= ld_data[i];
      else if (wr_en && (addr == AB'(i)))       bytes_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= 8'h00;
    else if (addr < AB'(NB))    rd_data <= bytes_q[addr];
    else                        rd_data <= 8'h00;
  end
endmodule

// File: rtl/cal_engine.sv
module cal_engine
  import cal_pkg::*;
#(
  parameter int UIP_DELAY = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_tick,
  input  logic          set_hold,
  input  logic          bin_mode,
  input  logic          hr24_mode,
  input  logic          dst_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          uip,
  output logic          upd_done
);
  localparam int CW = (UIP_DELAY > 1) ? $clog2(UIP_DELAY) : 1;

  cal_time_t          now_q;
  cal_time_t          base_t;
  cal_time_t          next_t;
  cal_time_t          dec_t;
  logic               fall_q;
  logic               fall_nxt;
  logic               busy_q;
  logic [CW-1:0]      cnt_q;
  logic               set_q;
  logic               dirty_q;
  logic               xfer;
  logic               load_w;
  logic               host_wr;
  logic [NF-1:0][7:0] user_bytes;
  logic [NF-1:0][7:0] enc_bytes;

  assign xfer    = busy_q && (cnt_q == '0);
  assign load_w  = set_q && !set_hold && dirty_q;
  assign host_wr = wr_en && set_hold;
  assign base_t  = load_w ? dec_t : now_q;

  cal_step u_step (
    .cur(base_t), .dst_en(dst_en), .fall_done(fall_q),
    .nxt(next_t), .fall_done_nxt(fall_nxt)
  );

  cal_codec u_codec (
    .t_in(next_t), .bytes_in(user_bytes), .bin(bin_mode), .h24(hr24_mode),
    .bytes_out(enc_bytes), .t_out(dec_t)
  );

  cal_user_regs #(.NB(NF), .AB(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(host_wr), .addr(addr), .wr_data(wr_data),
    .ld_en(xfer && !set_hold), .ld_data(enc_bytes),
    .bytes_q(user_bytes), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q    <= TIME_RST;
      fall_q   <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      set_q    <= 1'b0;
      dirty_q  <= 1'b0;
      uip      <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      set_q    <= set_hold;
      upd_done <= xfer;
      if (xfer) begin
        now_q  <= next_t;
        fall_q <= fall_nxt;
      end else if (load_w) begin
        now_q  <= dec_t;
      end
      if (load_w)       dirty_q <= 1'b0;
      else if (host_wr) dirty_q <= 1'b1;
      if (xfer)          busy_q <= 1'b0;
      else if (busy_q)   cnt_q  <= cnt_q - 1'b1;
      else if (sec_tick) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(UIP_DELAY - 1);
      end
      if (set_hold)                 uip <= 1'b0;
      else if (sec_tick && !busy_q) uip <= 1'b1;
      else if (xfer)                uip <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk
  import cal_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               sec_tick,
  input logic               set_hold,
  input logic               wr_en,
  input logic               uip,
  input logic               upd_done,
  input logic [NF-1:0][7:0] user_bytes,
  input cal_time_t          now_t
);
  a_r6_uip_low_in_set: assert property (@(posedge clk) disable iff (rst)
    set_hold |=> !uip);

  a_r6_user_frozen: assert property (@(posedge clk) disable iff (rst)
    (set_hold && !wr_en) |=> $stable(user_bytes));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

  a_r2_uip_from_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> $past(sec_tick));

  a_r4_time_in_range: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> (now_t.sec < 6'd60 && now_t.min < 6'd60 && now_t.hr < 5'd24));
endmodule

bind cal_engine cal_engine_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .set_hold(set_hold), .wr_en(wr_en),
  .uip(uip), .upd_done(upd_done), .user_bytes(user_bytes), .now_t(now_q)
);

// File: tb/cal_engine_bench.sv
module cal_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 0, rst = 1, sec_tick = 0, set_hold = 0;
  logic bin_mode = 0, hr24_mode = 1, dst_en = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  wire  [7:0] rd_data;
  wire        uip, upd_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_engine #(.UIP_DELAY(D)) u_cal_engine (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .set_hold(set_hold), .bin_mode(bin_mode),
    .hr24_mode(hr24_mode), .dst_en(dst_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .uip(uip), .upd_done(upd_done)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ms, mm, mh, mw, md, mo, my;
  bit mf, mbusy, muip, mupd, mset_q, mdirty;
  int mcnt, mrd;
  int mu[7];

  function automatic int enc(int v, bit b);
    return b ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int dec(int x, bit b);
    return b ? x % 128 : (x / 16) * 10 + x % 16;
  endfunction
  function automatic int mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic void m_advance();
    bit one59;
    one59 = (mh == 1 && mm == 59 && ms == 59 && mw == 1);
    if (dst_en && one59 && mo == 4 && md <= 7) begin
      ms = 0; mm = 0; mh = 3;
    end else if (dst_en && one59 && mo == 10 && md >= 25 && !mf) begin
      ms = 0; mm = 0; mh = 1; mf = 1;
    end else begin
      ms++;
      if (ms == 60) begin ms = 0; mm++; end
      if (mm == 60) begin mm = 0; mh++; end
      if (mh == 24) begin
        mh = 0;
        mw = (mw == 7) ? 1 : mw + 1;
        md++;
        if (md > mdays(mo, my)) begin md = 1; mo++; end
        if (mo == 13) begin mo = 1; my = (my == 99) ? 0 : my + 1; end
      end
      if (mh != 1) mf = 0;
    end
  endfunction

  function automatic int hour_byte(int h);
    int h12;
    if (hr24_mode) return enc(h, bin_mode);
    h12 = (h == 0) ? 12 : (h > 12) ? h - 12 : h;
    return ((h >= 12) ? 128 : 0) + enc(h12, bin_mode);
  endfunction
  function automatic int hour_val(int x);
    int v;
    if (hr24_mode) return dec(x, bin_mode);
    v = dec(x % 128, bin_mode);
    if (v == 12) return (x >= 128) ? 12 : 0;
    return (x >= 128) ? v + 12 : v;
  endfunction

  always @(posedge clk) begin
    bit xfer, load;
    int old_u[7];
    if (rst) begin
      ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
      mf = 0; mbusy = 0; muip = 0; mupd = 0; mset_q = 0; mdirty = 0; mcnt = 0; mrd = 0;
      mu = '{0, 0, 0, 1, 1, 1, 0};
    end else begin
      xfer  = mbusy && mcnt == 0;
      load  = mset_q && !set_hold && mdirty;
      old_u = mu;
      if (load) begin
        ms = dec(old_u[0], bin_mode); mm = dec(old_u[1], bin_mode); mh = hour_val(old_u[2]);
        mw = dec(old_u[3], bin_mode); md = dec(old_u[4], bin_mode);
        mo = dec(old_u[5], bin_mode); my = dec(old_u[6], bin_mode);
      end
      if (xfer) begin
        m_advance();
        if (!set_hold) mu = '{enc(ms, bin_mode), enc(mm, bin_mode), hour_byte(mh),
                              enc(mw, bin_mode), enc(md, bin_mode), enc(mo, bin_mode),
                              enc(my, bin_mode)};
      end
      if (set_hold && wr_en && addr < 7) mu[addr] = wr_data;
      mrd = (addr < 7) ? old_u[addr] : 0;
      if (load) mdirty = 0; else if (set_hold && wr_en) mdirty = 1;
      if (set_hold) muip = 0; else if (sec_tick && !mbusy) muip = 1; else if (xfer) muip = 0;
      if (xfer) mbusy = 0;
      else if (mbusy) mcnt--;
      else if (sec_tick) begin mbusy = 1; mcnt = D - 1; end
      mupd   = xfer;
      mset_q = set_hold;
    end
  end

  always @(negedge clk) if (!rst) begin
    check("R2/R6 uip vs model", int'(uip), int'(muip));
    check("R11 upd_done vs model", int'(upd_done), int'(mupd));
    check("R3/R4 rd_data vs model", int'(rd_data), mrd);
  end

  // ---------------- stimulus helpers ----------------
  task automatic rd_byte(int a, output int v);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic set_time(int b[7]);
    @(negedge clk); set_hold = 1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); wr_en = 1; addr = 3'(i); wr_data = 8'(b[i]);
    end
    @(negedge clk); wr_en = 0; set_hold = 0;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    repeat (D + 2) @(negedge clk);
  endtask

  task automatic expect_bytes(string req, int e[7]);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd_byte(i, v);
      check(req, v, e[i]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 uip after reset", int'(uip), 0);
    check("R1 upd_done after reset", int'(upd_done), 0);
    expect_bytes("R1 reset bytes", '{0, 0, 0, 1, 1, 1, 0});

    // R2 / R11 timing of the warning window and the pulse
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    check("R2 uip raised after tick", int'(uip), 1);
    repeat (D - 1) @(negedge clk);
    check("R2 uip still high before advance", int'(uip), 1);
    check("R11 no pulse before advance", int'(upd_done), 0);
    @(negedge clk);
    check("R2 uip low after advance", int'(uip), 0);
    check("R11 pulse after advance", int'(upd_done), 1);
    repeat (3) @(negedge clk);
    rd_byte(0, v); check("R2 second advanced", v, 1);

    // R4 / R3 full rollover in BCD
    set_time('{'h59, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99});
    do_tick();
    expect_bytes("R4 year rollover BCD", '{0, 0, 0, 1, 1, 1, 0});
    set_time('{'h09, 0, 0, 1, 1, 1, 0});
    do_tick();
    rd_byte(0, v); check("R3 BCD carry 09->10", v, 'h10);

    // R3 / R4 binary mode and leap years
    bin_mode = 1;
    set_time('{9, 0, 0, 1, 1, 1, 0});
    do_tick();
    rd_byte(0, v); check("R3 binary 9->10", v, 'h0A);
    set_time('{59, 59, 23, 3, 28, 2, 24});
    do_tick();
    expect_bytes("R4 leap Feb 29", '{0, 0, 0, 4, 29, 2, 24});
    set_time('{59, 59, 23, 4, 29, 2, 24});
    do_tick();
    expect_bytes("R4 leap Feb 29 to Mar 1", '{0, 0, 0, 5, 1, 3, 24});
    set_time('{59, 59, 23, 3, 28, 2, 23});
    do_tick();
    expect_bytes("R4 non-leap Feb 28 to Mar 1", '{0, 0, 0, 4, 1, 3, 23});

    // R5 12-hour BCD
    bin_mode = 0; hr24_mode = 0;
    set_time('{'h59, 'h59, 'h11, 2, 5, 5, 5});
    do_tick();
    rd_byte(2, v); check("R5 11AM to 12PM", v, 'h92);
    set_time('{'h59, 'h59, 'h92, 2, 5, 5, 5});
    do_tick();
    rd_byte(2, v); check("R5 12PM to 1PM", v, 'h81);
    set_time('{'h59, 'h59, 'h91, 2, 5, 5, 5});
    do_tick();
    expect_bytes("R5 11PM to 12AM", '{0, 0, 'h12, 3, 6, 5, 5});
    hr24_mode = 1;

    // R9 spring jump
    dst_en = 1;
    set_time('{'h59, 'h59, 'h01, 1, 'h03, 'h04, 1});
    do_tick();
    expect_bytes("R9 spring skip to 3AM", '{0, 0, 'h03, 1, 3, 4, 1});
    dst_en = 0;
    set_time('{'h59, 'h59, 'h01, 1, 'h03, 'h04, 1});
    do_tick();
    rd_byte(2, v); check("R9 no jump when disabled", v, 'h02);

    // R10 fall jump, once only
    dst_en = 1;
    set_time('{'h59, 'h59, 'h01, 1, 'h28, 'h10, 1});
    do_tick();
    expect_bytes("R10 fall back to 1AM", '{0, 0, 'h01, 1, 'h28, 'h10, 1});
    set_time('{'h59, 'h59, 'h01, 1, 'h28, 'h10, 1});
    do_tick();
    rd_byte(2, v); check("R10 second pass goes to 2AM", v, 'h02);
    dst_en = 0;

    // R6 frozen user copy, internal keeps counting
    @(negedge clk); set_hold = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
      check("R6 uip held low in set", int'(uip), 0);
      repeat (D + 2) @(negedge clk);
      rd_byte(0, v); check("R6 user second frozen", v, 0);
    end
    @(negedge clk); set_hold = 0;
    do_tick();
    rd_byte(0, v); check("R6 internal kept counting", v, 'h04);
    rd_byte(2, v); check("R6 hour after hold", v, 'h02);

    // R7 write ignored while not in set
    @(negedge clk); wr_en = 1; addr = 0; wr_data = 8'h33;
    @(negedge clk); wr_en = 0;
    rd_byte(0, v); check("R7 write ignored", v, 'h04);

    // R8 release coinciding with an advance
    @(negedge clk); set_hold = 1;
    @(negedge clk); wr_en = 1; addr = 0; wr_data = 8'h30;
    @(negedge clk); addr = 1; wr_data = 8'h20;
    @(negedge clk); addr = 2; wr_data = 8'h10;
    @(negedge clk); wr_en = 0; sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    repeat (D - 1) @(negedge clk);
    set_hold = 0;
    repeat (3) @(negedge clk);
    rd_byte(0, v); check("R8 collision second", v, 'h31);
    rd_byte(1, v); check("R8 collision minute", v, 'h20);
    rd_byte(2, v); check("R8 collision hour", v, 'h10);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule